// File: doc/BRIEF.md
# Translation Unit Control and Fault Status Registers

This block is the register front end of an address-translation unit. Software uses a plain register read and write bus to turn translation on or off. It can also ask the unit to quiesce: a block request stalls new translation requests, and a status bit reports when all outstanding transactions have drained. The translation path supplies a count of transactions still in flight. The block drives an enable line and a stall line back to that path.

The page walker reports faults as single-cycle events. Each event carries a faulting address, a direction flag and a 20-bit tag. Reads and writes go to separate channels, and each channel has its own address and info capture pair. A capture sets a pending bit in the interrupt status register, and the interrupt output is raised while any pending bit is set. Software clears pending bits by writing ones to a clear register. A channel whose pending bit is set keeps its first capture; later faults on that channel are not recorded until the bit is cleared.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset, xlat_enable, xlat_stall and irq are 0, and the control, status and interrupt status registers read 0.
- R2: The control register at offset 0x000 holds written bits [2:0] and reads them back. Bit 0 drives xlat_enable and bit 1 is the block request, so 0x5 means enabled, 0x7 means enabled and blocked, and 0x0 means disabled.
- R3: While control bit 1 is set, xlat_stall is 1. Status bit 0 (offset 0x008) becomes 1 at the first clock edge where control bit 1 was already registered and inflight_cnt is zero. It stays 1 while the block request holds, even if inflight_cnt rises again.
- R4: A control write that clears bit 1 (for example 0x5) drops xlat_stall and status bit 0 at the same clock edge as the write.
- R5: The config register at 0x004 and the table base register at 0x00C store and return all 32 bits.
- R6: A fault event with flt_is_wr=0 and no read fault pending stores flt_addr at 0x070 and an info word at 0x078. The info word is flt_tag in bits [19:0], 0 in bit 20 and zeros above. The event sets interrupt status bit 0 (offset 0x060).
- R7: A fault event with flt_is_wr=1 and no write fault pending stores flt_addr at 0x080 and the info word at 0x088, with bit 20 set to 1. The event sets interrupt status bit 1.
- R8: While a channel's pending bit is set, new faults on that channel do not change its address or info register.
- R9: Writing to 0x064 clears every interrupt status bit whose data bit is 1 and leaves the others. A read of 0x064 returns 0.
- R10: irq is 1 exactly when at least one interrupt status bit is set.
- R11: Reads of any other offset, including misaligned ones, return 0, and reg_rdata is 0 when reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; the data is returned in the same cycle |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| inflight_cnt | input | CNT_W | Outstanding transactions in the translation path |
| flt_valid | input | 1 | Fault event strobe from the walker |
| flt_is_wr | input | 1 | Fault direction: 1 for a write request |
| flt_addr | input | FADDR_W | Faulting address |
| flt_tag | input | 20 | Transaction information for the info word |
| xlat_enable | output | 1 | Translation enable |
| xlat_stall | output | 1 | Stall new translation requests |
| irq | output | 1 | Fault interrupt |

## Verification
The bench builds the block with ADDR_W=12 and a 4-bit inflight count. With ADDR_W=12 it can read every word offset of the 4 KB window and compare each one with a value it computes from the offset. It sweeps all eight control values and walks a single one through each of the 20 tag bits on both fault channels. The small count width makes it quick to move the drain between busy and idle, so the bench checks the exact edge at which the blocked bit sets and releases.

// File: rtl/xlat_csr_pkg.sv
package xlat_csr_pkg;

  localparam logic [31:0] OFS_CTRL   = 32'h000;
  localparam logic [31:0] OFS_CFG    = 32'h004;
  localparam logic [31:0] OFS_STAT   = 32'h008;
  localparam logic [31:0] OFS_PTBASE = 32'h00C;
  localparam logic [31:0] OFS_INTSTS = 32'h060;
  localparam logic [31:0] OFS_INTCLR = 32'h064;
  localparam logic [31:0] OFS_RADDR  = 32'h070;
  localparam logic [31:0] OFS_RINFO  = 32'h078;
  localparam logic [31:0] OFS_WADDR  = 32'h080;
  localparam logic [31:0] OFS_WINFO  = 32'h088;

  localparam int TAG_W        = 20;
  localparam int INFO_DIR_BIT = 20;
  localparam int NUM_CH       = 2;

  // Packs the fault info word: tag low, direction flag at bit 20.
  function automatic logic [31:0] info_word(input logic is_wr,
                                            input logic [TAG_W-1:0] tag);
    logic [31:0] w;
    w = '0;
    w[TAG_W-1:0] = tag;
    w[INFO_DIR_BIT] = is_wr;
    return w;
  endfunction

  // Blocked flag next state: set once registered request meets an idle path,
  // held while the request stays, dropped at once when the request goes.
  function automatic logic blocked_next(input logic req_q, input logic req_d,
                                        input logic held, input logic idle);
    return req_q & req_d & (held | idle);
  endfunction

endpackage

// File: rtl/xlat_blk_ctl.sv
module xlat_blk_ctl
  import xlat_csr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [2:0]       ctrl_wdata,
  input  logic [CNT_W-1:0] inflight,
  output logic [2:0]       ctrl_q,
  output logic             blocked
);

  logic req_d;
  logic path_idle;

  assign req_d     = ctrl_we ? ctrl_wdata[1] : ctrl_q[1];
  assign path_idle = (inflight == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      blocked <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      blocked <= blocked_next(ctrl_q[1], req_d, blocked, path_idle);
    end
  end

  // R3
  blocked_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> ctrl_q[1]);

  // R3
  blocked_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blocked) |-> ($past(inflight) == '0));

  // R4
  release_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_wdata[1]) |=> !blocked);

endmodule

// File: rtl/xlat_fault_chan.sv
module xlat_fault_chan
  import xlat_csr_pkg::*;
#(
  parameter int FADDR_W = 32,
  parameter bit IS_WR   = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt,
  input  logic [FADDR_W-1:0] evt_addr,
  input  logic [TAG_W-1:0]   evt_tag,
  input  logic               clr,
  output logic               pend,
  output logic [FADDR_W-1:0] addr_q,
  output logic [31:0]        info_q
);

  logic capture;

  assign capture = evt & ~pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      addr_q <= '0;
      info_q <= '0;
    end else begin
      pend <= (pend & ~clr) | capture;
      if (capture) begin
        addr_q <= evt_addr;
        info_q <= info_word(IS_WR, evt_tag);
      end
    end
  end

  // R8
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> ($stable(addr_q) && $stable(info_q)));

  // R6 R7
  dir_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (info_q[INFO_DIR_BIT] == IS_WR));

  // R9
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !pend);

endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
  import xlat_csr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 8,
  parameter int FADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [CNT_W-1:0]   inflight_cnt,
  input  logic               flt_valid,
  input  logic               flt_is_wr,
  input  logic [FADDR_W-1:0] flt_addr,
  input  logic [TAG_W-1:0]   flt_tag,
  output logic               xlat_enable,
  output logic               xlat_stall,
  output logic               irq
);

  localparam logic [ADDR_W-1:0] A_CTRL   = OFS_CTRL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CFG    = OFS_CFG[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_STAT   = OFS_STAT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_PTBASE = OFS_PTBASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_INTSTS = OFS_INTSTS[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_INTCLR = OFS_INTCLR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_RADDR  = OFS_RADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_RINFO  = OFS_RINFO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_WADDR  = OFS_WADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_WINFO  = OFS_WINFO[ADDR_W-1:0];

  logic [2:0]          ctrl_q;
  logic                blocked;
  logic [31:0]         cfg_q;
  logic [31:0]         ptbase_q;
  logic [NUM_CH-1:0]   pend;
  logic [NUM_CH-1:0]   int_clr;
  logic [FADDR_W-1:0]  fa   [NUM_CH];
  logic [31:0]         fi   [NUM_CH];
  logic                addr_hit;
  logic [31:0]         rd_mux;

  assign int_clr = (reg_wr && reg_addr == A_INTCLR) ? reg_wdata[NUM_CH-1:0] : '0;

  xlat_blk_ctl #(.CNT_W(CNT_W)) u_blk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (reg_wr && reg_addr == A_CTRL),
    .ctrl_wdata (reg_wdata[2:0]),
    .inflight   (inflight_cnt),
    .ctrl_q     (ctrl_q),
    .blocked    (blocked)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gen_ch
    xlat_fault_chan #(.FADDR_W(FADDR_W), .IS_WR(ch == 1)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (flt_valid && (flt_is_wr == (ch == 1))),
      .evt_addr (flt_addr),
      .evt_tag  (flt_tag),
      .clr      (int_clr[ch]),
      .pend     (pend[ch]),
      .addr_q   (fa[ch]),
      .info_q   (fi[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      ptbase_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CFG)    cfg_q    <= reg_wdata;
      if (reg_addr == A_PTBASE) ptbase_q <= reg_wdata;
    end
  end

  always_comb begin
    addr_hit = 1'b1;
    rd_mux   = '0;
    case (reg_addr)
      A_CTRL:   rd_mux[2:0] = ctrl_q;
      A_CFG:    rd_mux = cfg_q;
      A_STAT:   rd_mux[0] = blocked;
      A_PTBASE: rd_mux = ptbase_q;
      A_INTSTS: rd_mux[NUM_CH-1:0] = pend;
      A_INTCLR: rd_mux = '0;
      A_RADDR:  rd_mux[FADDR_W-1:0] = fa[0];
      A_RINFO:  rd_mux = fi[0];
      A_WADDR:  rd_mux[FADDR_W-1:0] = fa[1];
      A_WINFO:  rd_mux = fi[1];
      default:  addr_hit = 1'b0;
    endcase
  end

  assign reg_rdata   = reg_rd ? rd_mux : '0;
  assign xlat_enable = ctrl_q[0];
  assign xlat_stall  = ctrl_q[1];
  assign irq         = |pend;

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flt_valid));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !addr_hit) |-> (reg_rdata == '0));

  // R3
  stall_while_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> xlat_stall);

endmodule

// File: tb/xlat_ctl_regs_bench.sv
module xlat_ctl_regs_bench;

  localparam int ADDR_W = 12;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr, reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic [CNT_W-1:0]  inflight_cnt;
  logic              flt_valid, flt_is_wr;
  logic [31:0]       flt_addr;
  logic [19:0]       flt_tag;
  logic              xlat_enable, xlat_stall, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  xlat_ctl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FADDR_W(32)) u_xlat_ctl_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .inflight_cnt(inflight_cnt), .flt_valid(flt_valid), .flt_is_wr(flt_is_wr),
    .flt_addr(flt_addr), .flt_tag(flt_tag), .xlat_enable(xlat_enable),
    .xlat_stall(xlat_stall), .irq(irq)
  );

  function automatic logic [31:0] exp_info(input logic w, input logic [19:0] t);
    return {11'd0, w, t};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic fault(input logic w, input logic [31:0] a, input logic [19:0] t);
    @(negedge clk);
    flt_valid = 1'b1; flt_is_wr = w; flt_addr = a; flt_tag = t;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] ra, wa, ri, wi;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    inflight_cnt = '0; flt_valid = 0; flt_is_wr = 0; flt_addr = '0; flt_tag = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 enable", {31'd0, xlat_enable}, 0);
    chk("R1 stall", {31'd0, xlat_stall}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(12'h000, d); chk("R1 ctrl", d, 0);
    rd(12'h008, d); chk("R1 status", d, 0);
    rd(12'h060, d); chk("R1 intsts", d, 0);

    // R2 sweep of every control value with an idle path
    for (int v = 0; v < 8; v++) begin
      wr(12'h000, 32'(v));
      rd(12'h000, d); chk("R2 ctrl readback", d, 32'(v));
      chk("R2 enable", {31'd0, xlat_enable}, {31'd0, v[0]});
      chk("R3 stall", {31'd0, xlat_stall}, {31'd0, v[1]});
      tick(1);
      rd(12'h008, d); chk("R3 status sweep", d, {31'd0, v[1]});
    end
    wr(12'h000, 32'h5);
    tick(1);

    // R3 drain handshake
    inflight_cnt = 4'd3;
    wr(12'h000, 32'h7);
    chk("R3 stall on request", {31'd0, xlat_stall}, 1);
    rd(12'h008, d); chk("R3 busy not blocked", d, 0);
    tick(3);
    rd(12'h008, d); chk("R3 still draining", d, 0);
    inflight_cnt = 4'd0;
    rd(12'h008, d); chk("R3 before edge", d, 0);
    tick(1);
    rd(12'h008, d); chk("R3 blocked after drain", d, 1);
    inflight_cnt = 4'd2;
    tick(2);
    rd(12'h008, d); chk("R3 blocked holds", d, 1);
    // R4 release
    wr(12'h000, 32'h5);
    rd(12'h008, d); chk("R4 status released", d, 0);
    chk("R4 stall released", {31'd0, xlat_stall}, 0);
    chk("R4 enable kept", {31'd0, xlat_enable}, 1);
    // R3 timing from an idle path
    inflight_cnt = 4'd0;
    wr(12'h000, 32'h7);
    rd(12'h008, d); chk("R3 one edge after ctrl", d, 0);
    tick(1);
    rd(12'h008, d); chk("R3 second edge", d, 1);
    wr(12'h000, 32'h5);
    rd(12'h008, d); chk("R4 release idle", d, 0);

    // R5
    wr(12'h004, 32'hC0FF_EE11);
    wr(12'h00C, 32'h1234_5000);
    rd(12'h004, d); chk("R5 cfg", d, 32'hC0FF_EE11);
    rd(12'h00C, d); chk("R5 ptbase", d, 32'h1234_5000);

    // R6 read fault
    fault(1'b0, 32'hA000_1234, 20'h5_5AA5);
    chk("R10 irq on read fault", {31'd0, irq}, 1);
    rd(12'h060, d); chk("R6 intsts", d, 1);
    rd(12'h070, d); chk("R6 addr", d, 32'hA000_1234);
    rd(12'h078, d); chk("R6 info", d, exp_info(0, 20'h5_5AA5));
    // R8 second read fault ignored
    fault(1'b0, 32'hBBBB_0000, 20'hF_FFFF);
    rd(12'h070, d); chk("R8 addr kept", d, 32'hA000_1234);
    rd(12'h078, d); chk("R8 info kept", d, exp_info(0, 20'h5_5AA5));
    // R7 write fault
    fault(1'b1, 32'h0000_BEEF, 20'h0_0F0F);
    rd(12'h060, d); chk("R7 intsts", d, 3);
    rd(12'h080, d); chk("R7 addr", d, 32'h0000_BEEF);
    rd(12'h088, d); chk("R7 info", d, exp_info(1, 20'h0_0F0F));
    // R9 partial clear
    wr(12'h064, 32'h1);
    rd(12'h060, d); chk("R9 partial clear", d, 2);
    chk("R10 irq one pending", {31'd0, irq}, 1);
    rd(12'h064, d); chk("R9 clear reads zero", d, 0);
    fault(1'b0, 32'hCAFE_0000, 20'h1_2345);
    rd(12'h070, d); chk("R6 recapture", d, 32'hCAFE_0000);
    wr(12'h064, 32'h3);
    rd(12'h060, d); chk("R9 full clear", d, 0);
    chk("R10 irq low", {31'd0, irq}, 0);

    // R6 R7 walking-one tag sweep on both channels
    for (int b = 0; b < 20; b++) begin
      for (int w = 0; w < 2; w++) begin
        fault(w[0], 32'(b) << 4, 20'(1) << b);
        rd(w[0] ? 12'h088 : 12'h078, d);
        chk(w[0] ? "R7 tag sweep" : "R6 tag sweep", d, exp_info(w[0], 20'(1) << b));
        rd(w[0] ? 12'h080 : 12'h070, d);
        chk(w[0] ? "R7 addr sweep" : "R6 addr sweep", d, 32'(b) << 4);
        wr(12'h064, w[0] ? 32'h2 : 32'h1);
      end
    end

    // R11 full address sweep
    ra = 32'h1357_9BDF; ri = exp_info(0, 20'hA_BCDE);
    wa = 32'h2468_ACE0; wi = exp_info(1, 20'h3_1415);
    fault(1'b0, ra, 20'hA_BCDE);
    fault(1'b1, wa, 20'h3_1415);
    for (int a = 0; a < 4096; a++) begin
      logic [31:0] e;
      case (a)
        'h000: e = 32'h5;
        'h004: e = 32'hC0FF_EE11;
        'h00C: e = 32'h1234_5000;
        'h060: e = 32'h3;
        'h070: e = ra;
        'h078: e = ri;
        'h080: e = wa;
        'h088: e = wi;
        default: e = 32'h0;
      endcase
      rd(12'(a), d);
      chk("R11 address sweep", d, e);
    end
    reg_addr = 12'h004;
    #1 chk("R11 no read strobe", reg_rdata, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule